// File: doc/BRIEF.md
# Load-Store Alias Protection Unit

This unit guards loads that a scheduler has moved ahead of older stores. Each such load, when marked as protected, writes its starting byte address and its width into one slot of a small table; the load names the slot itself. A later store that is marked as checked carries a bit mask naming the slots it must be compared with. If the byte range of the store touches the byte range of any selected, valid slot, the unit raises an alias exception. Recovery logic then discards the speculative work.

The comparison takes place one stage after the store is presented. That is the stage in which the data cache access and the translation lookup complete. The exception is therefore a registered pulse in the cycle after the store. It carries the index of the lowest-numbered slot that matched. A commit or rollback pulse empties the table in one cycle. Ordinary loads and stores never reach this block.

Top module: `alias_guard`

## Requirements
- R1: After reset, alias_o and alias_idx_o are 0 and every slot is empty, so no store raises an exception until a slot is filled.
- R2: A cycle with prot_vld_i high writes slot prot_idx_i with start prot_addr_i and size code prot_size_i. This replaces whatever that slot held before.
- R3: When st_vld_i is high and the store range overlaps a valid slot whose bit in st_mask_i is set, alias_o is high in the following cycle for exactly that one cycle per store.
- R4: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A range covers [start, start+bytes). Two ranges overlap when each start is below the other range's end, so ranges that only touch do not alias.
- R5: Bit i of st_mask_i selects slot i. A slot whose bit is clear never causes an exception, whatever its range.
- R6: A cycle with st_vld_i low raises no exception in the next cycle, whatever st_addr_i and st_mask_i hold.
- R7: clear_i empties every slot at the next edge. A protected load in the same cycle as clear_i is dropped. A store in the same cycle as clear_i is still checked against the slots as they were before the clear.
- R8: With an exception, alias_idx_o gives the lowest-numbered selected slot that overlapped. Without one, alias_idx_o is 0.
- R9: A store is checked against the slots as they stand before the edge. A protected load in the same cycle as the store is not seen by that store.
- R10: Range ends are formed one bit wider than the address, so a range at the top of the address space does not wrap around to overlap address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Commit or rollback pulse; empties the table |
| prot_vld_i | input | 1 | Protected load records a slot this cycle |
| prot_idx_i | input | 3 | Slot written by the protected load |
| prot_addr_i | input | 32 | Start byte address of the protected load |
| prot_size_i | input | 2 | Size code of the protected load (1, 2, 4 or 8 bytes) |
| st_vld_i | input | 1 | Checked store presented this cycle |
| st_mask_i | input | 8 | Slot select mask of the store |
| st_addr_i | input | 32 | Start byte address of the store |
| st_size_i | input | 2 | Size code of the store |
| alias_o | output | 1 | Alias exception pulse, one cycle after the store |
| alias_idx_o | output | 3 | Lowest matching slot index, 0 without exception |

## Verification
Wrong slot state shows up at the ports as a wrong alias_o or alias_idx_o. This appears in the cycle after the first checked store whose range or mask reaches the corrupted slot. To expose stale or missing slots, the bench keeps probing with stores that hit and narrowly miss recorded ranges. These include touching boundaries, wrapped ends, overlapping slots and same-cycle clears and fills. A behavioural table model checks every cycle, so a single bad bit is reported one cycle after the store that observes it.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int unsigned SIZE_W = 2;

  // size code -> byte count (1,2,4,8)
  function automatic logic [3:0] size_bytes(input logic [SIZE_W-1:0] code);
    return 4'(1) << code;
  endfunction
endpackage

// File: rtl/alias_entry_table.sv
module alias_entry_table #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 clear_i,
  input  logic                                 wr_i,
  input  logic [IDX_W-1:0]                     wr_idx_i,
  input  logic [ADDR_W-1:0]                    wr_start_i,
  input  logic [ADDR_W:0]                      wr_end_i,
  output logic [N_ENTRIES-1:0]                 valid_o,
  output logic [N_ENTRIES-1:0][ADDR_W-1:0]     start_o,
  output logic [N_ENTRIES-1:0][ADDR_W:0]       end_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    logic hit_wr;
    assign hit_wr = wr_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        start_o[g] <= '0;
        end_o[g]   <= '0;
      end else if (clear_i) begin
        valid_o[g] <= 1'b0;  // clear wins over same-cycle fill
      end else if (hit_wr) begin
        valid_o[g] <= 1'b1;
        start_o[g] <= wr_start_i;
        end_o[g]   <= wr_end_i;
      end
    end
  end
endmodule

// File: rtl/alias_range_cmp.sv
module alias_range_cmp #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic [N_ENTRIES-1:0]             valid_i,
  input  logic [N_ENTRIES-1:0]             sel_i,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] start_i,
  input  logic [N_ENTRIES-1:0][ADDR_W:0]   end_i,
  input  logic [ADDR_W-1:0]                st_start_i,
  input  logic [ADDR_W:0]                  st_end_i,
  output logic [N_ENTRIES-1:0]             hit_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic lo_ok, hi_ok;
    assign lo_ok    = {1'b0, st_start_i} < end_i[g];
    assign hi_ok    = {1'b0, start_i[g]} < st_end_i;
    assign hit_o[g] = valid_i[g] && sel_i[g] && lo_ok && hi_ok;
  end
endmodule

// File: rtl/alias_lowest_pick.sv
module alias_lowest_pick #(
  parameter int unsigned N_ENTRIES = 8,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] hit_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/alias_guard.sv
module alias_guard #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned SIZE_W   = alias_pkg::SIZE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 prot_vld_i,
  input  logic [IDX_W-1:0]     prot_idx_i,
  input  logic [ADDR_W-1:0]    prot_addr_i,
  input  logic [SIZE_W-1:0]    prot_size_i,
  input  logic                 st_vld_i,
  input  logic [N_ENTRIES-1:0] st_mask_i,
  input  logic [ADDR_W-1:0]    st_addr_i,
  input  logic [SIZE_W-1:0]    st_size_i,
  output logic                 alias_o,
  output logic [IDX_W-1:0]     alias_idx_o
);
  logic [ADDR_W:0]                  prot_end, st_end;
  logic [N_ENTRIES-1:0]             ent_valid, hit;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_start;
  logic [N_ENTRIES-1:0][ADDR_W:0]   ent_end;
  logic                             any_hit;
  logic [IDX_W-1:0]                 hit_idx;

  // one extra bit keeps top-of-space ranges from wrapping
  assign prot_end = {1'b0, prot_addr_i} + (ADDR_W+1)'(alias_pkg::size_bytes(prot_size_i));
  assign st_end   = {1'b0, st_addr_i}   + (ADDR_W+1)'(alias_pkg::size_bytes(st_size_i));

  alias_entry_table #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .wr_i       (prot_vld_i),
    .wr_idx_i   (prot_idx_i),
    .wr_start_i (prot_addr_i),
    .wr_end_i   (prot_end),
    .valid_o    (ent_valid),
    .start_o    (ent_start),
    .end_o      (ent_end)
  );

  alias_range_cmp #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_cmp (
    .valid_i    (ent_valid),
    .sel_i      (st_mask_i),
    .start_i    (ent_start),
    .end_i      (ent_end),
    .st_start_i (st_addr_i),
    .st_end_i   (st_end),
    .hit_o      (hit)
  );

  alias_lowest_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .hit_i (hit),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  // result stage: aligned with cache completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alias_o     <= 1'b0;
      alias_idx_o <= '0;
    end else begin
      alias_o     <= st_vld_i && any_hit;
      alias_idx_o <= (st_vld_i && any_hit) ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/alias_guard_chk.sv
module alias_guard_chk #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clear_i,
  input logic                 prot_vld_i,
  input logic [IDX_W-1:0]     prot_idx_i,
  input logic [ADDR_W-1:0]    prot_addr_i,
  input logic                 st_vld_i,
  input logic [N_ENTRIES-1:0] st_mask_i,
  input logic [ADDR_W-1:0]    st_addr_i,
  input logic                 alias_o,
  input logic [IDX_W-1:0]     alias_idx_o
);
  AST_NO_STORE_NO_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_vld_i |=> !alias_o); // R6

  AST_EMPTY_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_vld_i && st_mask_i == '0) |=> !alias_o); // R5

  AST_CLEARED_TABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clear_i) && st_vld_i) |=> !alias_o); // R7

  AST_FRESH_SLOT_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(prot_vld_i) && !$past(clear_i) && st_vld_i
     && st_addr_i == $past(prot_addr_i) && st_mask_i[$past(prot_idx_i)]) |=> alias_o); // R3

  AST_IDX_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alias_o |-> alias_idx_o == '0); // R8
endmodule

bind alias_guard alias_guard_chk #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_alias_guard.sv
`timescale 1ns/1ps
module tb_alias_guard;
  localparam int N = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        clear_i = 0, prot_vld_i = 0, st_vld_i = 0;
  logic [2:0]  prot_idx_i = 0;
  logic [31:0] prot_addr_i = 0, st_addr_i = 0;
  logic [1:0]  prot_size_i = 0, st_size_i = 0;
  logic [7:0]  st_mask_i = 0;
  logic        alias_o;
  logic [2:0]  alias_idx_o;

  int checks = 0, errors = 0;
  bit    m_vld [N];
  longint m_s [N], m_e [N];

  always #2.5 clk_i = ~clk_i;

  alias_guard dut (.*);

  task automatic set_in(bit clr, bit pv, int pi, longint pa, int ps,
                        bit sv, int sm, longint sa, int ss);
    clear_i = clr; prot_vld_i = pv; prot_idx_i = 3'(pi); prot_addr_i = 32'(pa);
    prot_size_i = 2'(ps); st_vld_i = sv; st_mask_i = 8'(sm); st_addr_i = 32'(sa);
    st_size_i = 2'(ss);
  endtask

  task automatic step(string tag);
    bit ea = 0; int ei = 0;
    longint ss = st_addr_i, se = longint'(st_addr_i) + (1 << st_size_i);
    for (int i = N - 1; i >= 0; i--)
      if (st_vld_i && st_mask_i[i] && m_vld[i] && ss < m_e[i] && m_s[i] < se) begin
        ea = 1; ei = i;
      end
    if (clear_i) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else if (prot_vld_i) begin
      m_vld[prot_idx_i] = 1;
      m_s[prot_idx_i] = prot_addr_i;
      m_e[prot_idx_i] = longint'(prot_addr_i) + (1 << prot_size_i);
    end
    @(posedge clk_i); #1;
    checks++;
    if (alias_o !== ea || alias_idx_o !== 3'(ei)) begin
      errors++;
      $display("FAIL %s alias=%0b idx=%0d expected alias=%0b idx=%0d",
               tag, alias_o, alias_idx_o, ea, ei);
    end
    set_in(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    #12 rst_ni = 1'b1; #1;
    checks++;
    if (alias_o !== 1'b0 || alias_idx_o !== 3'd0) begin
      errors++;
      $display("FAIL R1 alias=%0b idx=%0d expected alias=0 idx=0", alias_o, alias_idx_o);
    end
    set_in(0,0,0,0,0, 1,8'hFF,'h100,3);        step("R1 empty table");
    set_in(0,1,2,'h100,2, 0,0,0,0);            step("R2 fill slot 2");
    set_in(0,0,0,0,0, 1,8'h04,'h103,0);        step("R3 hit last byte");
    set_in(0,0,0,0,0, 1,8'h04,'h104,1);        step("R4 touch above");
    set_in(0,0,0,0,0, 1,8'h04,'hFC,2);         step("R4 touch below");
    set_in(0,0,0,0,0, 1,8'h04,'hF8,3);         step("R4 eight bytes below");
    set_in(0,0,0,0,0, 1,8'h04,'hFA,3);         step("R4 eight bytes straddle");
    set_in(0,0,0,0,0, 1,8'hFB,'h100,2);        step("R5 slot unselected");
    set_in(0,1,5,'h100,1, 0,0,0,0);            step("R2 fill slot 5");
    set_in(0,0,0,0,0, 1,8'hFF,'h101,0);        step("R8 lowest of two");
    set_in(0,0,0,0,0, 1,8'h20,'h101,0);        step("R8 only slot 5");
    set_in(0,0,0,0,0, 0,8'hFF,'h100,3);        step("R6 store not valid");
    set_in(0,0,0,0,0, 0,0,0,0);                step("R6 idle");
    set_in(0,1,2,'h200,0, 0,0,0,0);            step("R2 replace slot 2");
    set_in(0,0,0,0,0, 1,8'h04,'h100,0);        step("R2 old range gone");
    set_in(0,1,7,'h300,3, 1,8'h80,'h300,0);    step("R9 same-cycle fill");
    set_in(0,0,0,0,0, 1,8'h80,'h307,0);        step("R9 visible next cycle");
    set_in(1,0,0,0,0, 1,8'h80,'h300,0);        step("R7 store with clear");
    set_in(0,0,0,0,0, 1,8'hFF,'h300,3);        step("R7 table empty");
    set_in(1,1,1,'h400,3, 0,0,0,0);            step("R7 clear beats fill");
    set_in(0,0,0,0,0, 1,8'hFF,'h400,3);        step("R7 fill dropped");
    set_in(0,1,0,'hFFFF_FFFC,2, 0,0,0,0);      step("R10 fill top");
    set_in(0,0,0,0,0, 1,8'h01,'h0,3);          step("R10 no wrap");
    set_in(0,0,0,0,0, 1,8'h01,'hFFFF_FFFF,0);  step("R10 top byte");
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      set_in(lfsr[15:12] == 0, lfsr[0], int'(lfsr[3:1]), 'h500 + longint'(lfsr[9:4]),
             int'(lfsr[11:10]), lfsr[1] | lfsr[5], int'(lfsr[13:6]),
             'h500 + longint'(lfsr[14:9]), int'(lfsr[4:3]));
      step("R3 mixed traffic");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule